// File: doc/BRIEF.md
# Bus Cycle Sequencer with Region Wait States

This block turns a single memory request into a processor-style bus cycle made of clock states T1, T2, T3, any number of wait states TW, and T4. A request carries an address, a read/write flag and write data. The block latches the request, pulses an address-latch strobe in T1, drives the read or write strobe, a data-enable and a direction line, and either presents write data or captures read data from the bus.

An internal wait generator compares the latched address with a region defined by a base and a mask. On a hit it loads a counter with a configured wait count and holds its ready line low until the counter runs out. The sequencer samples ready in T3 and in every TW. Each TW lengthens the strobe, the data setup and the data hold by one clock, so a slow device gets whole extra clock periods. A one-cycle done pulse in T4 ends the cycle. Read data is valid with that pulse.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held and after release with no request, busy, done, the address-latch strobe, both strobes, data enable, direction and the write-data enable are all low, and ready is high.
- R2: A request accepted while idle starts T1 on the next cycle. The address-latch strobe is high in exactly that one cycle. The address output equals the request address from T1 through T4, even if the request address input changes during the cycle.
- R3: The write strobe is high from T2 through the last T3/TW state, for 2+N consecutive cycles, where N is the number of wait states. A read cycle drives the read strobe for the same cycles instead. The two strobes are never high together, and both are low in T1 and T4.
- R4: Data enable is high from T2 through T4, which is 3+N cycles. The direction output is 1 (transmit) for every busy cycle of a write and 0 (receive) for every cycle of a read.
- R5: The write-data enable is high together with data enable only on writes, and the data output then carries the request's write data. On reads it stays low.
- R6: A request is in the slow region when (address AND mask) equals (base AND mask). A hit inserts N TW states, where N is the configured wait count. A miss inserts none. A cycle therefore lasts 4+N cycles, from T1 to done.
- R7: On a hit with N>0, ready is low for N+1 consecutive cycles starting in T2, and it is high again in the last TW. On a miss, or with N=0, ready stays high.
- R8: Done is high for exactly one cycle, in T4. On a read, the read-data output then holds the bus input sampled in the last strobe cycle.
- R9: A request held high while busy is ignored until T4 completes. The block spends one idle cycle after T4 and then starts the next T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request; accepted when idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| slow_base_i | input | AW | Slow-region base |
| slow_mask_i | input | AW | Slow-region compare mask |
| slow_waits_i | input | WCW | Wait states for a region hit |
| din_i | input | DW | Data bus input for reads |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle completion pulse in T4 |
| rdata_o | output | DW | Captured read data |
| ale_o | output | 1 | Address-latch strobe, T1 |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| den_o | output | 1 | Data enable, T2 to T4 |
| dtr_o | output | 1 | Direction: 1 transmit, 0 receive |
| addr_o | output | AW | Address bus |
| dout_o | output | DW | Write data bus |
| dout_oe_o | output | 1 | Write data drive enable |
| ready_o | output | 1 | Ready from the wait generator |

## Verification
The sweep covers every wait count from 0 to 3 with both directions. Addresses are chosen to hit the region, miss it, and sit exactly on both sides of its boundary. Hits and misses at the same wait count show whether the mask compare, and not the count alone, decides the stretch. The boundary addresses catch an off-by-one in the compare. The wait counts 0 and 1 show whether the strobe widths grow by exactly one clock per TW. A zero mask makes every address a hit. A final run holds the request high and changes its address mid-cycle, which shows that a busy cycle ignores new requests and that the block spends one idle cycle before restarting.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW  = 20,
  parameter int DW  = 8,
  parameter int WCW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_i,
  input  logic           req_we_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [DW-1:0]  req_wdata_i,
  input  logic [AW-1:0]  slow_base_i,
  input  logic [AW-1:0]  slow_mask_i,
  input  logic [WCW-1:0] slow_waits_i,
  input  logic [DW-1:0]  din_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [DW-1:0]  rdata_o,
  output logic           ale_o,
  output logic           rd_o,
  output logic           wr_o,
  output logic           den_o,
  output logic           dtr_o,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  dout_o,
  output logic           dout_oe_o,
  output logic           ready_o
);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} st_t;

  st_t            st;
  logic [AW-1:0]  a_q;
  logic [DW-1:0]  wd_q;
  logic [DW-1:0]  rd_q;
  logic           we_q;
  logic [WCW-1:0] wcnt;
  logic           hit;
  logic           strobe;

  assign hit    = (a_q & slow_mask_i) == (slow_base_i & slow_mask_i);
  assign strobe = (st == S_T2) || (st == S_T3) || (st == S_TW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      a_q  <= '0;
      wd_q <= '0;
      rd_q <= '0;
      we_q <= 1'b0;
      wcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_i) begin
          a_q  <= req_addr_i;
          wd_q <= req_wdata_i;
          we_q <= req_we_i;
          st   <= S_T1;
        end
        S_T1: begin
          wcnt <= hit ? slow_waits_i : '0;
          st   <= S_T2;
        end
        S_T2: st <= S_T3;
        S_T3, S_TW: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
            st   <= S_TW;
          end else begin
            if (!we_q) rd_q <= din_i;
            st <= S_T4;
          end
        end
        S_T4: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = st != S_IDLE;
  assign done_o    = st == S_T4;
  assign ale_o     = st == S_T1;
  assign wr_o      = strobe && we_q;
  assign rd_o      = strobe && !we_q;
  assign den_o     = strobe || (st == S_T4);
  assign dtr_o     = busy_o && we_q;
  assign dout_oe_o = den_o && we_q;
  assign dout_o    = wd_q;
  assign addr_o    = a_q;
  assign rdata_o   = rd_q;
  assign ready_o   = wcnt == '0;

  assert_ale_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (!rd_o && !wr_o && !den_o && !done_o));

  assert_ale_then_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> (rd_o || wr_o));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o));

  assert_strobe_ends_in_t4_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_o) || $fell(rd_o)) |-> done_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_wait_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && (st == S_T3 || st == S_TW)) |=> (st == S_TW && (rd_o || wr_o)));

  assert_miss_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T2 && !hit) |-> ready_o);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ale_o) |-> $stable(addr_o));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int WCW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0, req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0, slow_base_i = '0, slow_mask_i = '0;
  logic [DW-1:0] req_wdata_i = '0, din_i = '0;
  logic [WCW-1:0] slow_waits_i = '0;
  logic busy_o, done_o, ale_o, rd_o, wr_o, den_o, dtr_o, dout_oe_o, ready_o;
  logic [DW-1:0] rdata_o, dout_o;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq #(.AW(AW), .DW(DW), .WCW(WCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .slow_base_i(slow_base_i), .slow_mask_i(slow_mask_i),
    .slow_waits_i(slow_waits_i), .din_i(din_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .ale_o(ale_o), .rd_o(rd_o),
    .wr_o(wr_o), .den_o(den_o), .dtr_o(dtr_o), .addr_o(addr_o),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o), .ready_o(ready_o));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cycle(input bit we, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input logic [DW-1:0] rdin,
                           input bit hold);
    int n, len, ale_n, ale_k, wr_n, rd_n, den_n, oe_n, rdy_lo, dtr_bad, addr_bad, dout_bad, both;
    int ready_first_lo;
    logic [DW-1:0] rdat;
    n = (((a & slow_mask_i) == (slow_base_i & slow_mask_i))) ? int'(slow_waits_i) : 0;
    len = -1; ale_n = 0; ale_k = -1; wr_n = 0; rd_n = 0; den_n = 0; oe_n = 0;
    rdy_lo = 0; dtr_bad = 0; addr_bad = 0; dout_bad = 0; both = 0; ready_first_lo = -1;
    rdat = '0;
    @(negedge clk);
    req_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = wd; din_i = rdin;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ale_o) begin ale_n++; ale_k = k; end
      if (wr_o) wr_n++;
      if (rd_o) rd_n++;
      if (wr_o && rd_o) both++;
      if (den_o) den_n++;
      if (dout_oe_o) begin oe_n++; if (dout_o != wd) dout_bad++; end
      if (!ready_o) begin rdy_lo++; if (ready_first_lo < 0) ready_first_lo = k; end
      if (dtr_o != we) dtr_bad++;
      if (addr_o != a) addr_bad++;
      if (hold) req_addr_i = a ^ 20'h5A5A5;
      else req_i = 1'b0;
      if (done_o) begin len = k + 1; rdat = rdata_o; break; end
    end
    // R6: cycle length 4+N
    check(len == 4 + n, "R6 cycle length", len, 4 + n);
    // R2: one ALE, in the first cycle; address held
    check(ale_n == 1 && ale_k == 0, "R2 ale only in T1", ale_n, 1);
    check(addr_bad == 0, "R2 address held T1..T4", addr_bad, 0);
    // R3: strobe widths
    check(wr_n == (we ? 2 + n : 0), "R3 write strobe width", wr_n, we ? 2 + n : 0);
    check(rd_n == (we ? 0 : 2 + n), "R3 read strobe width", rd_n, we ? 0 : 2 + n);
    check(both == 0, "R3 strobes exclusive", both, 0);
    // R4: data enable and direction
    check(den_n == 3 + n, "R4 data enable span", den_n, 3 + n);
    check(dtr_bad == 0, "R4 direction", dtr_bad, 0);
    // R5: write data drive
    check(oe_n == (we ? 3 + n : 0) && dout_bad == 0, "R5 write data drive", oe_n, we ? 3 + n : 0);
    // R7: ready low span
    check(rdy_lo == (n > 0 ? n + 1 : 0), "R7 ready low cycles", rdy_lo, n > 0 ? n + 1 : 0);
    if (n > 0) check(ready_first_lo == 1, "R7 ready low from T2", ready_first_lo, 1);
    // R8: read data with done
    if (!we) check(rdat == rdin, "R8 read data", rdat, rdin);
    @(negedge clk);
    check(!done_o && !busy_o, "R8 R9 done single, then idle", {done_o, busy_o}, 0);
    if (hold) begin
      @(negedge clk);
      check(ale_o && busy_o, "R9 restart after idle cycle", ale_o, 1);
      req_i = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (!busy_o) break;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [AW-1:0] addrs [5];
    addrs[0] = 20'h00123; addrs[1] = 20'hA0023; addrs[2] = 20'hAFFFF;
    addrs[3] = 20'h9FFFF; addrs[4] = 20'hB0000;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy_o && !done_o && !ale_o && !rd_o && !wr_o && !den_o && !dtr_o && !dout_oe_o && ready_o,
          "R1 reset outputs", {busy_o, done_o, ale_o, rd_o, wr_o, den_o, dtr_o, dout_oe_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && ready_o && !ale_o, "R1 idle after reset", busy_o, 0);

    slow_base_i = 20'hA0000;
    slow_mask_i = 20'hF0000;
    for (int w = 0; w < 4; w++) begin
      slow_waits_i = WCW'(w);
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < 5; i++)
          run_cycle(d[0], addrs[i], 8'h30 + 8'(w * 16 + i), 8'hC0 ^ 8'(w * 8 + i), 1'b0);
    end

    // R6: zero mask, every address is a hit
    slow_mask_i = '0;
    slow_waits_i = 4'd2;
    run_cycle(1'b0, 20'h01234, 8'h11, 8'h7E, 1'b0);
    run_cycle(1'b1, 20'hFFFFF, 8'hE1, 8'h00, 1'b0);

    // R9: request held high and its address changed mid-cycle
    slow_mask_i = 20'hF0000;
    slow_waits_i = 4'd1;
    run_cycle(1'b1, 20'hA0100, 8'h5C, 8'h00, 1'b1);
    run_cycle(1'b0, 20'h00100, 8'h00, 8'h99, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule